// File: doc/BRIEF.md
# Windowed Key-Code Watchdog

A supervisory timer built on an 8-bit up counter that advances on ticks taken from a free-running prescaler. Software services it by writing key values to a code port. A service write can be refused if it comes too soon in the period. Such a write flags a fault and does not restart the count. If the counter passes its top value, the block emits a one-cycle interrupt request or a one-cycle reset request, depending on a control bit. It then keeps counting from zero.

A control register holds the enable bit, the early-window size, the period select and the action select. While the enable bit is set, the other fields are frozen. They may be loaded in the same write that sets the enable bit. Stopping the timer takes two steps: clear the enable bit, then write the stop key. The timer starts by itself when a warm-up-done pulse arrives after reset. Sticky status flags and a counter monitor can be read back through a combinational read port.

Top module: `wdw_top`

## Requirements
- R1: After reset the control register reads 0x9C, status reads 0x00, the counter monitor reads 0 and the counter is stopped. Control layout: [5] enable, [4] action select, [3:2] period select, [1:0] window. Register addresses: 0 control, 1 code, 2 status, 3 counter monitor.
- R2: A one-cycle warmDone pulse sets the enable bit, and counting starts on the following tick.
- R3: While running, the counter gains one on each tick and is otherwise unchanged. The prescaler starts at reset and runs freely. A tick occurs every 2^(BASE_SHIFT+2p) clocks, where p is the period select, so an overflow spans 256 ticks.
- R4: Writing 0x4E to the code register while running, with the counter at or above window*64, zeroes the counter on the next edge.
- R5: Writing 0x4E while running with the counter below window*64 leaves the counter unreset. It gives a one-cycle irq in the next cycle and sets status bit 1. Window 0 never rejects.
- R6: Writing 0xB1 with the enable bit at 0 stops counting and zeroes the counter. With the enable bit at 1 it has no effect. Code values other than 0x4E and 0xB1 are ignored.
- R7: While the enable bit is 1, control writes change only the enable bit. With the enable bit at 0, a write loads all of [5:0], including in the same write that sets the enable bit.
- R8: On a tick at count 255 the counter wraps to 0 and status bit 0 is set. The next cycle carries a one-cycle pulse on irq if the action select is 0, or on rstReq if it is 1.
- R9: Control bits 7 and 6 always read as 1 and 0.
- R10: Writing 1 to a status bit clears it, unless the same flag is set in that cycle. Address 3 reads the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| warmDone | input | 1 | Warm-up-complete pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request pulse |
| rstReq | output | 1 | Reset request pulse |

## Verification
The bench builds the block with BASE_SHIFT set to 2, so one tick lasts 4 clocks at period select 0 and a full overflow takes 1024 clocks. With that setting, overflows under both action selects can be reached within the run. So can early and late service writes against a 128-count window and the stop sequence. The behavioural model follows the prescaler from reset, so the exact cycle of every wrap and pulse is compared.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CNT_W = 8;
  localparam logic [7:0] KEY_SERVICE = 8'h4E;
  localparam logic [7:0] KEY_STOP    = 8'hB1;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CODE = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_MON  = 2'd3
  } wdw_addr_e;

  typedef struct packed {
    logic       en;
    logic       sel;
    logic [1:0] per;
    logic [1:0] win;
  } wdw_cfg_t;

  typedef struct packed {
    logic       run;
    logic       clear;
    logic [1:0] per;
  } wdw_strobe_t;

  localparam wdw_cfg_t CFG_RESET = '{en: 1'b0, sel: 1'b1, per: 2'b11, win: 2'b00};
endpackage

// File: rtl/wdw_datapath.sv
module wdw_datapath
  import wdw_pkg::*;
#(
  parameter int BASE_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdw_strobe_t      strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfEvt
);
  localparam int PRE_W = BASE_SHIFT + 6;

  logic [PRE_W-1:0] preCnt;
  logic [3:0]       stageTick;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar k = 0; k < 4; k++) begin : g_stage
    assign stageTick[k] = &preCnt[BASE_SHIFT+2*k-1:0];
  end

  assign tick   = stageTick[strobe.per];
  assign ovfEvt = strobe.run && tick && (&cnt) && !strobe.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (strobe.clear)        cnt <= '0;
    else if (strobe.run && tick)  cnt <= cnt + 1'b1;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cnt == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.clear && !tick) |=> $stable(cnt));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.clear) |=> $stable(cnt));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> (cnt == '0));
endmodule

// File: rtl/wdw_ctrl.sv
module wdw_ctrl
  import wdw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             warmDone,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic [1:0]       rdAddr,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovfEvt,
  output wdw_strobe_t      strobe,
  output logic [7:0]       rdData,
  output logic             irq,
  output logic             rstReq
);
  localparam int WIN_SHIFT = CNT_W - 2;

  wdw_cfg_t         cfg;
  logic             running;
  logic             ovfFlag;
  logic             earlyFlag;
  logic             codeWr, ctrlWr, statWr;
  logic             svcKey, stopKey, early, goodSvc, goodStop;
  logic [CNT_W-1:0] boundary;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign codeWr   = wrEn && (wrAddr == ADDR_CODE);
  assign statWr   = wrEn && (wrAddr == ADDR_STAT);
  assign svcKey   = codeWr && (wrData == KEY_SERVICE);
  assign stopKey  = codeWr && (wrData == KEY_STOP);
  assign boundary = {cfg.win, {WIN_SHIFT{1'b0}}};
  assign early    = running && svcKey && (cnt < boundary);
  assign goodSvc  = running && svcKey && !early;
  assign goodStop = stopKey && !cfg.en;

  assign strobe = '{run: running, clear: goodSvc || goodStop, per: cfg.per};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= CFG_RESET;
      running <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (cfg.en) cfg.en <= wrData[5];
        else        cfg    <= wrData[5:0];
        if (wrData[5]) running <= 1'b1;
      end
      if (goodStop) running <= 1'b0;
      if (warmDone) begin
        cfg.en  <= 1'b1;
        running <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      earlyFlag <= 1'b0;
      irq       <= 1'b0;
      rstReq    <= 1'b0;
    end else begin
      ovfFlag   <= ovfEvt || (ovfFlag && !(statWr && wrData[0]));
      earlyFlag <= early  || (earlyFlag && !(statWr && wrData[1]));
      irq       <= early || (ovfEvt && !cfg.sel);
      rstReq    <= ovfEvt && cfg.sel;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = {2'b10, cfg};
      ADDR_STAT: rdData = {6'b0, earlyFlag, ovfFlag};
      ADDR_MON:  rdData = cnt;
      default:   rdData = 8'h00;
    endcase
  end

  assert_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.en |=> $stable({cfg.sel, cfg.per, cfg.win}));
  assert_early_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    early |=> irq);
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  assert_stop_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopKey && cfg.en) |=> running);
  assert_ctrl_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_CTRL) |-> (rdData[7:6] == 2'b10));
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int BASE_SHIFT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       warmDone,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       rstReq
);
  wdw_strobe_t      strobe;
  logic [CNT_W-1:0] cnt;
  logic             ovfEvt;

  wdw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .warmDone(warmDone), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .cnt(cnt),
    .ovfEvt(ovfEvt), .strobe(strobe), .rdData(rdData), .irq(irq),
    .rstReq(rstReq)
  );

  wdw_datapath #(.BASE_SHIFT(BASE_SHIFT)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt), .ovfEvt(ovfEvt)
  );
endmodule

// File: tb/test_wdw_top.sv
module test_wdw_top;
  localparam int CLK_PERIOD = 10;
  localparam int BS = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       warmDone = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] rdAddr = 2'd3;
  logic [7:0] rdData;
  logic       irq, rstReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int irqSeen = 0;
  int rstSeen = 0;
  bit cmpOn = 1'b0;

  // behavioural reference state
  int   mPre = 0;
  int   mCnt = 0;
  bit   mRun = 0, mEn = 0, mSel = 1;
  int   mPer = 3, mWin = 0;
  bit   mOvf = 0, mEarly = 0, mIrq = 0, mRst = 0;

  wdw_top #(.BASE_SHIFT(BS)) i_wdw_top (
    .clk(clk), .rstN(rstN), .warmDone(warmDone), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irq(irq), .rstReq(rstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] modelRead(logic [1:0] a);
    case (a)
      2'd0: return {2'b10, mEn, mSel, 2'(mPer), 2'(mWin)};
      2'd2: return {6'b0, mEarly, mOvf};
      2'd3: return 8'(mCnt);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mRun = 0; mEn = 0; mSel = 1; mPer = 3; mWin = 0;
      mOvf = 0; mEarly = 0; mIrq = 0; mRst = 0;
    end else begin
      bit svc, stp, early, good, stop, tick, ovf;
      int mask;
      svc   = wrEn && wrAddr == 2'd1 && wrData == 8'h4E;
      stp   = wrEn && wrAddr == 2'd1 && wrData == 8'hB1;
      early = mRun && svc && (mCnt < mWin * 64);
      good  = mRun && svc && !early;
      stop  = stp && !mEn;
      mask  = (1 << (BS + 2 * mPer)) - 1;
      tick  = (mPre & mask) == mask;
      ovf   = mRun && tick && mCnt == 255 && !(good || stop);
      mIrq  = early || (ovf && !mSel);
      mRst  = ovf && mSel;
      if (wrEn && wrAddr == 2'd2) begin
        if (wrData[0]) mOvf = 0;
        if (wrData[1]) mEarly = 0;
      end
      if (ovf) mOvf = 1;
      if (early) mEarly = 1;
      if (good || stop) mCnt = 0;
      else if (mRun && tick) mCnt = (mCnt + 1) % 256;
      if (wrEn && wrAddr == 2'd0) begin
        if (mEn) mEn = wrData[5];
        else begin
          mEn = wrData[5]; mSel = wrData[4];
          mPer = int'(wrData[3:2]); mWin = int'(wrData[1:0]);
        end
        if (wrData[5]) mRun = 1;
      end
      if (stop) mRun = 0;
      if (warmDone) begin mEn = 1; mRun = 1; end
      mPre = mPre + 1;
    end
  end

  // per-cycle comparison of outputs and the selected read value
  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (irq !== mIrq || rstReq !== mRst || rdData !== modelRead(rdAddr)) begin
        errors++;
        $display("FAIL R3 R4 R5 R6 R8 cycle %0d: irq=%b rst=%b rd[%0d]=%h expected irq=%b rst=%b rd=%h",
                 cycles, irq, rstReq, rdAddr, rdData, mIrq, mRst, modelRead(rdAddr));
      end
      if (irq) irqSeen++;
      if (rstReq) rstSeen++;
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    rdAddr = a; #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rdData, exp);
    end
    rdAddr = 2'd3;
  endtask

  task automatic expectTrue(input bit cond, input int act, input int exp, input string tag);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int irqBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R1 R9: reset contents
    expectRead(2'd0, 8'h9C, "R1 R9 reset control");
    expectRead(2'd2, 8'h00, "R1 reset status");
    expectRead(2'd3, 8'h00, "R1 reset counter");
    waitCycles(20);
    expectRead(2'd3, 8'h00, "R1 stopped before warm-up");
    // R7: unlocked write loads fields
    writeReg(2'd0, 8'h00);
    expectRead(2'd0, 8'h80, "R7 R9 unlocked load");
    // R2: warm-up pulse starts the timer
    @(negedge clk); #1; warmDone = 1'b1;
    @(negedge clk); #1; warmDone = 1'b0;
    expectRead(2'd0, 8'hA0, "R2 enable after warm-up");
    waitCycles(40);
    expectTrue(mCnt > 0, mCnt, 1, "R2 R3 counting started");
    // R7: locked fields
    writeReg(2'd0, 8'h2F);
    expectRead(2'd0, 8'hA0, "R7 locked fields");
    // R8: overflow with action select 0 -> irq
    irqBefore = irqSeen;
    waitCycles(1100);
    expectRead(2'd2, 8'h01, "R8 overflow flag");
    expectTrue(irqSeen > irqBefore, irqSeen, irqBefore + 1, "R8 irq on overflow");
    expectTrue(rstSeen == 0, rstSeen, 0, "R8 no reset request when select 0");
    // R10: write-one-to-clear
    writeReg(2'd2, 8'h01);
    expectRead(2'd2, 8'h00, "R10 status clear");
    // R6: ignored code, locked stop key
    writeReg(2'd1, 8'h12);
    expectRead(2'd2, 8'h00, "R6 other code ignored");
    writeReg(2'd1, 8'hB1);
    waitCycles(12);
    expectTrue(mRun, 0, 1, "R6 stop key ignored while enabled");
    expectRead(2'd3, 8'(mCnt), "R6 counter still running");
    // R6: two-step stop
    writeReg(2'd0, 8'h00);
    expectRead(2'd0, 8'h80, "R6 R7 enable cleared");
    writeReg(2'd1, 8'hB1);
    waitCycles(50);
    expectRead(2'd3, 8'h00, "R6 stopped and zeroed");
    // R7: fields loaded with the enabling write: sel1 per0 win2
    writeReg(2'd0, 8'h32);
    expectRead(2'd0, 8'hB2, "R7 load with enable");
    // R5: early service
    irqBefore = irqSeen;
    writeReg(2'd1, 8'h4E);
    waitCycles(2);
    expectRead(2'd2, 8'h02, "R5 early flag");
    expectTrue(irqSeen == irqBefore + 1, irqSeen, irqBefore + 1, "R5 early irq pulse");
    expectTrue(mCnt > 0, mCnt, 1, "R5 counter not reset");
    writeReg(2'd2, 8'h02);
    expectRead(2'd2, 8'h00, "R10 early flag clear");
    // R4: late service zeroes the counter
    waitCycles(600);
    expectTrue(mCnt >= 128, mCnt, 128, "R4 past window boundary");
    writeReg(2'd1, 8'h4E);
    expectTrue(mCnt <= 1, mCnt, 0, "R4 counter restarted");
    expectRead(2'd3, 8'(mCnt), "R4 counter readback");
    expectRead(2'd2, 8'h00, "R4 no early flag");
    // R8: overflow with action select 1 -> reset request
    waitCycles(1100);
    expectTrue(rstSeen >= 1, rstSeen, 1, "R8 reset request pulse");
    expectRead(2'd2, 8'h01, "R8 overflow flag again");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule